// File: doc/BRIEF.md
# I2C Target with Pointer-Based Register Access

This block is an I2C target that runs entirely on the system clock. It synchronizes the SCL and SDA lines and finds their edges in the system clock domain. It drives SDA only through an open-drain pull-low enable. On the register side it gives a host access to 128 eight-bit registers through a simple port: an address, a write data bus with a one-cycle write strobe, and a read data bus with a one-cycle read strobe.

A transfer starts with the target's 7-bit address. In a write-addressed transfer, the byte after the address is a pointer byte. Its seven low bits select the starting register, and its top bit selects whether the pointer steps after each data byte. Any later bytes in the same transfer are written through the register port. A read is a write-addressed transfer that carries only the pointer byte, followed by a repeated start and the address with the read bit set. The target then streams registers from the pointer for as long as the host acknowledges each byte. The pointer survives stops and repeated starts, so a later read without a pointer byte continues where the last access left off.

Top module: `i2c_regport_target`

## Requirements
- R1: After reset or after a stop (SDA rising while SCL is high), the target leaves SDA released. It ignores every clocked bit until a start (SDA falling while SCL is high), and a start at any point restarts address reception.
- R2: The target acknowledges the first byte after a start only when its upper seven bits equal 0011101 in binary. On any other address it keeps SDA released for the rest of the transfer.
- R3: On the ninth clock after each byte it receives (address, pointer byte and data bytes), the target pulls SDA low for the whole high phase. While the host sends bits, SDA stays released.
- R4: In a write-addressed transfer, the first byte after the address acknowledge loads bits 6..0 into the register pointer. Bit 7 of that byte enables auto-increment (1) or disables it (0).
- R5: Each later byte of a write-addressed transfer produces exactly one single-cycle reg_we pulse. During that pulse, reg_addr is the current pointer and reg_wdata is the byte, received MSB first.
- R6: With auto-increment enabled, the pointer advances by one after each byte written or fetched for reading. With it disabled, every byte uses the same register.
- R7: An advancing pointer wraps from 127 to 0.
- R8: After an address with the read bit (bit 0 = 1), the target sends the register at the pointer, MSB first. It fetches each byte with one single-cycle reg_re pulse, with reg_addr equal to the pointer, before that byte's first bit is driven. reg_we and reg_re are never high together.
- R9: During a read, a host acknowledge (SDA low) on the ninth clock requests the next byte. A missing acknowledge ends the read: the target fetches nothing more and keeps SDA released until a start or stop.
- R10: The pointer is kept across stops and repeated starts, so a read without a new pointer byte continues from the last position.
- R11: The target changes its SDA drive only after a detected SCL falling edge (or a start or stop), never while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 7 | Register pointer presented to the register space |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Contents of the register at reg_addr |
| reg_re | output | 1 | One-cycle strobe marking the cycle reg_rdata is taken |

## Verification
Writes are tried with a pointer byte that has auto-increment set, one that has it cleared, and one that starts at 126. These three runs separate stepping, holding and wrapping of the pointer. Reads are tried as multi-byte bursts, as a burst with a fixed pointer, as a burst across the 127-to-0 boundary, and as a read with no pointer byte after an earlier read. The last case shows that the pointer is kept and that no fetch happens after a refused byte. Wrong addresses and bytes clocked without a start must produce no acknowledge and no strobe. A per-clock reference model of the expected strobe order catches any extra, missing or misaddressed register access.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_SUB,
      ST_WDATA,
      ST_TX,
      ST_RACK,
      ST_SKIP
   } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
module i2c_tgt_sync #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{INIT}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_tgt_cond.sv
`timescale 1ns/1ps
module i2c_tgt_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_ptr.sv
`timescale 1ns/1ps
module i2c_tgt_ptr #(
   parameter int AW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_ptr,
   input  logic          load_inc,
   input  logic          adv,
   output logic [AW-1:0] ptr,
   output logic          ainc
);
   localparam logic [AW-1:0] PTR_LAST = {AW{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr  <= '0;
         ainc <= 1'b0;
      end else if (load) begin
         ptr  <= load_ptr;
         ainc <= load_inc;
      end else if (adv && ainc) begin
         ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
      end
   end
endmodule

// File: rtl/i2c_regport_target.sv
`timescale 1ns/1ps
module i2c_regport_target #(
   parameter logic [6:0] DEV_ADDR    = 7'b0011101,
   parameter int         REG_AW      = 7,
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [REG_AW-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              reg_re
);
   import i2c_tgt_pkg::*;

   localparam int                CNT_W    = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(DATA_W - 1);

   if (DATA_W != 8) begin : g_bad_dw
      $error("i2c_regport_target: bus bytes are 8 bits wide");
   end
   if (REG_AW < 1 || REG_AW > 7) begin : g_bad_aw
      $error("i2c_regport_target: pointer width must fit the 7 low pointer-byte bits");
   end

   // line conditioning
   logic [1:0] pins_raw, pins_s;
   logic       scl_s, sda_s;
   assign pins_raw = {sda_i, scl_i};

   for (genvar i = 0; i < 2; i++) begin : g_sync
      i2c_tgt_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (pins_raw[i]),
         .q     (pins_s[i])
      );
   end
   assign scl_s = pins_s[0];
   assign sda_s = pins_s[1];

   logic scl_rise, scl_fall, start_det, stop_det;

   i2c_tgt_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   // transfer state
   tgt_state_e        state, after_ack;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] wdata_q;
   logic              we_q, re_q, rack_ok;
   logic              byte_done;

   assign byte_done = scl_fall && (cnt == CNT_FULL);

   // pointer
   logic              ptr_load, ptr_ainc;
   logic [REG_AW-1:0] ptr;

   assign ptr_load = (state == ST_SUB) && byte_done && !start_det && !stop_det;

   i2c_tgt_ptr #(.AW(REG_AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_ptr (shreg[REG_AW-1:0]),
      .load_inc (shreg[DATA_W-1]),
      .adv      (we_q | re_q),
      .ptr      (ptr),
      .ainc     (ptr_ainc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         after_ack <= ST_IDLE;
         cnt       <= '0;
         shreg     <= '0;
         wdata_q   <= '0;
         we_q      <= 1'b0;
         re_q      <= 1'b0;
         rack_ok   <= 1'b0;
      end else begin
         we_q <= 1'b0;
         re_q <= 1'b0;
         if (re_q) shreg <= reg_rdata;

         if (stop_det) begin
            state <= ST_IDLE;
            cnt   <= '0;
         end else if (start_det) begin
            state <= ST_ADDR;
            cnt   <= '0;
         end else begin
            case (state)
               ST_ADDR, ST_SUB, ST_WDATA: begin
                  if (scl_rise && cnt != CNT_FULL) begin
                     shreg <= {shreg[DATA_W-2:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (byte_done) begin
                     cnt <= '0;
                     if (state == ST_ADDR) begin
                        if (shreg[DATA_W-1:1] == DEV_ADDR) begin
                           state     <= ST_ACK;
                           after_ack <= shreg[0] ? ST_TX : ST_SUB;
                           re_q      <= shreg[0];
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else begin
                        state     <= ST_ACK;
                        after_ack <= ST_WDATA;
                        if (state == ST_WDATA) begin
                           we_q    <= 1'b1;
                           wdata_q <= shreg;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     state <= after_ack;
                     cnt   <= '0;
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt == CNT_LAST) begin
                        state <= ST_RACK;
                        cnt   <= '0;
                     end else begin
                        shreg <= {shreg[DATA_W-2:0], 1'b0};
                        cnt   <= cnt + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     rack_ok <= ~sda_s;
                     re_q    <= ~sda_s;
                  end else if (scl_fall) begin
                     state <= rack_ok ? ST_TX : ST_SKIP;
                     cnt   <= '0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe    = (state == ST_ACK) || ((state == ST_TX) && !shreg[DATA_W-1]);
   assign reg_addr  = ptr;
   assign reg_wdata = wdata_q;
   assign reg_we    = we_q;
   assign reg_re    = re_q;
endmodule

// File: rtl/i2c_regport_target_chk.sv
`timescale 1ns/1ps
module i2c_regport_target_chk #(
   parameter int REG_AW = 7
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    scl_fall,
   input logic                    start_det,
   input logic                    stop_det,
   input logic                    sda_oe,
   input logic                    reg_we,
   input logic                    reg_re,
   input logic [REG_AW-1:0]       reg_addr,
   input logic                    ptr_ainc,
   input i2c_tgt_pkg::tgt_state_e state
);
   import i2c_tgt_pkg::*;

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe); // R1

   AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe); // R9

   AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we); // R5

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re)); // R8

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_we || reg_re) && ptr_ainc) |=> (reg_addr == REG_AW'($past(reg_addr) + 1'b1))); // R6

   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_we || reg_re) && ptr_ainc && (reg_addr == {REG_AW{1'b1}})) |=> (reg_addr == '0)); // R7

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_we || reg_re) && !ptr_ainc) |=> $stable(reg_addr)); // R6

   AST_SDA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det))); // R11
endmodule

bind i2c_regport_target i2c_regport_target_chk #(.REG_AW(REG_AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_fall  (scl_fall),
   .start_det (start_det),
   .stop_det  (stop_det),
   .sda_oe    (sda_oe),
   .reg_we    (reg_we),
   .reg_re    (reg_re),
   .reg_addr  (reg_addr),
   .ptr_ainc  (ptr_ainc),
   .state     (state)
);

// File: tb/i2c_regport_target_test.sv
`timescale 1ns/1ps
module i2c_regport_target_test;
   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_bus;
   logic       sda_oe;
   logic [6:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic       reg_we, reg_re;

   always #2.5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_regport_target uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_bus),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata),
      .reg_re    (reg_re)
   );

   // register space served to the target
   logic [7:0] pmem [128];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) pmem[i] <= 8'h00;
      end else if (reg_we) begin
         pmem[reg_addr] <= reg_wdata;
      end
   end
   assign reg_rdata = pmem[reg_addr];

   // reference model
   logic [7:0]  mmem [128];
   int          m_ptr;
   bit          m_ainc;
   logic [14:0] wq[$];
   logic [6:0]  rq[$];

   int  tests = 0, fails = 0;
   int  mon_tests = 0, mon_fails = 0;
   bit  done = 1'b0;

   task automatic check(input string req, input int act, input int exp, input string what);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // per-clock comparison against the model
   logic scl_prev = 1'b1, oe_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (scl_m && scl_prev) begin
            mon_tests++;
            if (sda_oe != oe_prev) begin
               mon_fails++;
               $display("FAIL R11 sda drive changed with SCL high: actual %0b expected %0b", sda_oe, oe_prev);
            end
         end
         if (reg_we) begin
            mon_tests++;
            if (wq.size() == 0) begin
               mon_fails++;
               $display("FAIL R5 unexpected write: actual %0h/%0h expected none", reg_addr, reg_wdata);
            end else begin
               logic [14:0] e;
               e = wq.pop_front();
               if ({reg_addr, reg_wdata} != e) begin
                  mon_fails++;
                  $display("FAIL R5 write: actual %0h/%0h expected %0h/%0h", reg_addr, reg_wdata, e[14:8], e[7:0]);
               end
            end
         end
         if (reg_re) begin
            mon_tests++;
            if (rq.size() == 0) begin
               mon_fails++;
               $display("FAIL R9 unexpected fetch: actual %0h expected none", reg_addr);
            end else begin
               logic [6:0] a;
               a = rq.pop_front();
               if (reg_addr != a) begin
                  mon_fails++;
                  $display("FAIL R8 fetch address: actual %0h expected %0h", reg_addr, a);
               end
            end
         end
      end
      scl_prev = scl_m;
      oe_prev  = sda_oe;
   end

   task automatic wait_q();
      repeat (Q) @(posedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m = 1'b1; wait_q();
   endtask

   task automatic write_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wait_q();
         scl_m = 1'b1; wait_q();
         check("R3", sda_oe, 0, "released while host sends");
         wait_q();
         scl_m = 1'b0;
      end
      sda_m = 1'b1; wait_q();
      scl_m = 1'b1; wait_q();
      ack = !sda_bus;
      wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic read_byte(input bit give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wait_q();
         scl_m = 1'b1; wait_q();
         b[i] = sda_bus;
         wait_q();
         scl_m = 1'b0; wait_q();
      end
      sda_m = give_ack ? 1'b0 : 1'b1;
      wait_q();
      scl_m = 1'b1; wait_q(); wait_q();
      scl_m = 1'b0; wait_q();
      sda_m = 1'b1;
   endtask

   function automatic void model_sub(input logic [7:0] sub);
      m_ptr  = int'(sub[6:0]);
      m_ainc = sub[7];
   endfunction

   function automatic void model_step();
      if (m_ainc) m_ptr = (m_ptr + 1) % 128;
   endfunction

   task automatic wr_xfer(input logic [7:0] sub, input int n, input logic [31:0] bytes, input string req);
      bit ack;
      bus_start();
      write_byte(8'h3A, ack); check("R2", ack, 1, "address ack");
      model_sub(sub);
      write_byte(sub, ack);   check("R4", ack, 1, "pointer byte ack");
      for (int i = 0; i < n; i++) begin
         logic [7:0] d;
         d = bytes[31-8*i -: 8];
         wq.push_back({7'(m_ptr), d});
         mmem[m_ptr] = d;
         model_step();
         write_byte(d, ack); check(req, ack, 1, "data ack");
      end
      bus_stop();
   endtask

   task automatic rd_xfer(input bit with_sub, input logic [7:0] sub, input int n, input string req);
      bit         ack;
      logic [7:0] exp [4];
      logic [7:0] got;
      bus_start();
      if (with_sub) begin
         write_byte(8'h3A, ack); check("R2", ack, 1, "address ack");
         model_sub(sub);
         write_byte(sub, ack);   check("R4", ack, 1, "pointer byte ack");
         bus_start();
      end
      for (int i = 0; i < n; i++) begin
         exp[i] = mmem[m_ptr];
         rq.push_back(7'(m_ptr));
         model_step();
      end
      write_byte(8'h3B, ack); check("R8", ack, 1, "read address ack");
      for (int i = 0; i < n; i++) begin
         read_byte(i != n - 1, got);
         check(req, got, exp[i], "read byte");
      end
      read_byte(1'b0, got);
      check("R9", got, 8'hFF, "bus released after refused byte");
      bus_stop();
   endtask

   initial begin
      for (int i = 0; i < 128; i++) mmem[i] = 8'h00;
      m_ptr = 0; m_ainc = 1'b0;
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", sda_oe, 0, "reset sda drive");
      check("R1", reg_we, 0, "reset write strobe");
      check("R1", reg_re, 0, "reset read strobe");

      // foreign address: no ack on any byte
      begin
         bit ack;
         bus_start();
         write_byte(8'h3C, ack); check("R2", ack, 0, "foreign address ack");
         write_byte(8'h85, ack); check("R2", ack, 0, "byte after foreign address");
         bus_stop();
      end

      wr_xfer(8'h85, 4, 32'hA1B2C3D4, "R5");          // 5..8 stepping
      wr_xfer(8'h10, 2, 32'h11220000, "R6");          // held pointer
      wr_xfer(8'hFE, 3, 32'h01020300, "R7");          // 126,127,0
      repeat (4) @(negedge clk);
      check("R6", pmem[16], 8'h22, "held pointer keeps last byte");
      check("R6", pmem[17], 8'h00, "held pointer leaves neighbour");
      check("R7", pmem[0], 8'h03, "wrapped write");

      rd_xfer(1'b1, 8'h85, 3, "R8");                  // A1 B2 C3
      rd_xfer(1'b0, 8'h00, 1, "R10");                 // continues at 8: D4
      rd_xfer(1'b1, 8'h06, 2, "R6");                  // B2 B2
      rd_xfer(1'b1, 8'hFF, 2, "R7");                  // mem127, mem0

      // bits clocked without a start after a stop are ignored
      begin
         bit ack;
         scl_m = 1'b0; wait_q();
         write_byte(8'h3A, ack); check("R1", ack, 0, "byte without start");
         bus_stop();
      end

      repeat (20) @(negedge clk);
      check("R5", wq.size(), 0, "pending writes");
      check("R8", rq.size(), 0, "pending fetches");

      done = 1'b1;
      tests += mon_tests;
      fails += mon_fails;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests += mon_tests + 1;
         fails += mon_fails + 1;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule